// File: doc/BRIEF.md
# Quadrature Position Counter

This block keeps a 16-bit signed-agnostic position count from two external signals, A and B. In count-and-direction operation, A acts as a count strobe and B as a direction line. In phase operation, A and B are treated as two square waves in quadrature. The counter then moves one step on every single-signal transition, which gives four counts per cycle. The step is up or down depending on which phase leads.

A single polarity input does two jobs. It selects which edge of the strobe is active, and it reverses the sense of direction in both operations. Both raw signals are resynchronised by a two-flop stage before any edge is looked for.

A 2-bit prescaler code slows the internal sampling rate to once every one, two, three or four clocks. An enable freezes the count, and while it is low the internal edge history keeps following the inputs. In phase operation, a transition where both signals change at once is illegal. It is not counted, and it raises a one-cycle error flag.

Top module: `quad_counter`

## Requirements
- R1: During and right after reset, cnt_o is 0 and err_o is 0.
- R2: With mode_i=0 and pol_i=1, a rising edge on in_a_i steps the counter by one, and a falling edge on in_a_i has no effect on cnt_o.
- R3: With mode_i=0 and pol_i=0, a falling edge on in_a_i steps the counter by one, and a rising edge on in_a_i has no effect on cnt_o.
- R4: With mode_i=0, an active edge counts up when in_b_i equals pol_i and counts down otherwise. A change on in_b_i alone never moves the counter.
- R5: With mode_i=1 and pol_i=1, each single-signal transition moves the counter by one. The sequence {B,A} = 00, 01, 11, 10 (A leading) counts up, and the reverse order counts down.
- R6: With mode_i=1 and pol_i=0, the sense of R5 is inverted: A leading counts down and B leading counts up.
- R7: With mode_i=1, a sample in which A and B both differ from the previous sample leaves cnt_o unchanged. It drives err_o high for exactly that one update, and err_o is never high for mode_i=0.
- R8: Prescaler code pre_code_i = 0, 1, 2, 3 samples the synchronised inputs, and updates the counter, once every 1, 2, 3 or 4 clocks respectively.
- R9: While en_i is 0, cnt_o holds and err_o stays 0. Input transitions made while disabled are not counted after en_i returns to 1.
- R10: The counter moves by at most one per clock and wraps modulo 2^16 (0 minus 1 is 0xFFFF, 0xFFFF plus 1 is 0).
- R11: With pre_code_i=0, a transition applied to the raw inputs before clock edge k shows on cnt_o after clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counting enable |
| mode_i | input | 1 | 0: count-and-direction, 1: phase quadrature |
| pol_i | input | 1 | Active edge and direction sense |
| pre_code_i | input | 2 | Sample rate divider code (divide by code+1) |
| in_a_i | input | 1 | Raw strobe / phase A signal |
| in_b_i | input | 1 | Raw direction / phase B signal |
| cnt_o | output | 16 | Position count |
| err_o | output | 1 | One-cycle flag for an illegal phase transition |

## Verification
On every cycle, the bound assertions check the following: the count never moves by more than one step modulo 2^16, it is frozen while disabled, it does not move on an error update, and an error implies an enabled phase-mode sample. Which edge counts, which direction applies under each polarity, the x4 phase sequences, the prescaler spacing and the two-clock synchroniser latency can only be shown by the bench. Its behavioural model predicts the exact cycle at which the count changes, and hand-computed totals are checked at the end of each scenario.

// File: rtl/qdc_pkg.sv
package qdc_pkg;
  typedef enum logic {
    QDC_CNT_DIR = 1'b0,
    QDC_PHASE   = 1'b1
  } qdc_mode_e;

  typedef struct packed {
    logic step;
    logic up;
    logic err;
  } qdc_evt_t;

  localparam int unsigned QDC_IDX_A = 0;
  localparam int unsigned QDC_IDX_B = 1;
endpackage

// File: rtl/qdc_sync.sv
module qdc_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] ff_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[s] <= '0;
        else         ff_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[s] <= '0;
        else         ff_q[s] <= ff_q[s-1];
      end
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/qdc_prescaler.sv
module qdc_prescaler #(
  parameter int unsigned PRE_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] code_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q;

  // >= so that lowering the code mid-count never stalls the divider
  assign tick_o = en_i && (div_q >= code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (!en_i || tick_o)   div_q <= '0;
    else                        div_q <= div_q + PRE_W'(1);
  end
endmodule

// File: rtl/qdc_decode.sv
module qdc_decode
  import qdc_pkg::*;
(
  input  logic [1:0] prev_i,
  input  logic [1:0] cur_i,
  input  qdc_mode_e  mode_i,
  input  logic       pol_i,
  output qdc_evt_t   evt_o
);
  logic [1:0] delta;
  logic       a_rise;
  logic       a_fall;
  logic       a_leads;

  assign delta   = prev_i ^ cur_i;
  assign a_rise  = ~prev_i[QDC_IDX_A] &  cur_i[QDC_IDX_A];
  assign a_fall  =  prev_i[QDC_IDX_A] & ~cur_i[QDC_IDX_A];
  // forward gray step {B,A}: 00->01->11->10->00
  assign a_leads = prev_i[QDC_IDX_B] ^ cur_i[QDC_IDX_A];

  always_comb begin
    evt_o = '0;
    unique case (mode_i)
      QDC_CNT_DIR: begin
        evt_o.step = pol_i ? a_rise : a_fall;
        evt_o.up   = ~(cur_i[QDC_IDX_B] ^ pol_i);
      end
      QDC_PHASE: begin
        if (delta == 2'b11) begin
          evt_o.err = 1'b1;
        end else if (delta != 2'b00) begin
          evt_o.step = 1'b1;
          evt_o.up   = ~(a_leads ^ pol_i);
        end
      end
      default: evt_o = '0;
    endcase
  end
endmodule

// File: rtl/quad_counter.sv
module quad_counter
  import qdc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PRE_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             pol_i,
  input  logic [PRE_W-1:0] pre_code_i,
  input  logic             in_a_i,
  input  logic             in_b_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_o
);
  localparam int unsigned IN_W = 2;

  logic [IN_W-1:0]  raw;
  logic [IN_W-1:0]  cur;
  logic [IN_W-1:0]  prev_q;
  logic             tick;
  qdc_evt_t         evt;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;

  assign raw[QDC_IDX_A] = in_a_i;
  assign raw[QDC_IDX_B] = in_b_i;

  qdc_sync #(
    .W      (IN_W),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (cur)
  );

  qdc_prescaler #(
    .PRE_W (PRE_W)
  ) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .code_i (pre_code_i),
    .tick_o (tick)
  );

  qdc_decode i_dec (
    .prev_i (prev_q),
    .cur_i  (cur),
    .mode_i (qdc_mode_e'(mode_i)),
    .pol_i  (pol_i),
    .evt_o  (evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      // history follows inputs while disabled: no stale edge on re-enable
      if (!en_i || tick) prev_q <= cur;
      err_q <= tick & evt.err;
      if (tick && evt.step) begin
        cnt_q <= evt.up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;
endmodule

// File: rtl/quad_counter_chk.sv
module quad_counter_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             mode_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             err_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (cnt_o == '0 && err_o == 1'b0)
        else $error("R1 outputs not cleared in reset");
    end
  end

  p_unit_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == $past(cnt_o)) ||
    (cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1))) ||
    (cnt_o == CNT_W'($past(cnt_o) - CNT_W'(1))))
    else $error("R10 counter jumped by more than one");

  p_hold_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_o))
    else $error("R9 counter moved while disabled");

  p_err_enabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(en_i))
    else $error("R9 error raised while disabled");

  p_err_no_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(cnt_o))
    else $error("R7 counter moved on illegal transition");

  p_err_phase_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(mode_i))
    else $error("R7 error raised outside phase mode");
endmodule

bind quad_counter quad_counter_chk #(
  .CNT_W (CNT_W)
) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .mode_i (mode_i),
  .cnt_o  (cnt_o),
  .err_o  (err_o)
);

// File: tb/test_quad_counter.sv
module test_quad_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        mode;
  logic        pol;
  logic [1:0]  pre_code;
  logic        in_a;
  logic        in_b;
  logic [15:0] cnt_o;
  logic        err_o;

  int    checks = 0;
  int    errs   = 0;
  bit    done   = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";
  int    ph = 0;

  // behavioural reference state
  logic [1:0] sync_q[$];
  logic [1:0] m_cur;
  logic [1:0] m_prev;
  int         m_pre;
  int         m_cnt;
  logic       m_err;
  bit         m_tick;
  bit         m_fwd;

  always #2 clk = ~clk;

  quad_counter i_quad_counter (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .mode_i     (mode),
    .pol_i      (pol),
    .pre_code_i (pre_code),
    .in_a_i     (in_a),
    .in_b_i     (in_b),
    .cnt_o      (cnt_o),
    .err_o      (err_o)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  function automatic logic [1:0] gray(input int i);
    case (i % 4)
      0: gray = 2'b00;
      1: gray = 2'b01;
      2: gray = 2'b11;
      default: gray = 2'b10;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q = {2'b00, 2'b00};
      m_prev = 2'b00;
      m_pre  = 0;
      m_cnt  = 0;
      m_err  = 1'b0;
    end else begin
      m_cur  = sync_q[0];
      m_tick = en && (m_pre >= int'(pre_code));
      m_err  = 1'b0;
      if (m_tick) begin
        if (!mode) begin
          if (pol ? (m_cur[0] && !m_prev[0]) : (!m_cur[0] && m_prev[0]))
            m_cnt = (m_cur[1] == pol) ? m_cnt + 1 : m_cnt - 1;
        end else if ((m_cur ^ m_prev) == 2'b11) begin
          m_err = 1'b1;
        end else if (m_cur != m_prev) begin
          m_fwd = (m_prev == 2'b00 && m_cur == 2'b01) || (m_prev == 2'b01 && m_cur == 2'b11) ||
                  (m_prev == 2'b11 && m_cur == 2'b10) || (m_prev == 2'b10 && m_cur == 2'b00);
          m_cnt = (m_fwd == pol) ? m_cnt + 1 : m_cnt - 1;
        end
        m_cnt = (m_cnt + 65536) % 65536;
      end
      if (!en || m_tick) m_prev = m_cur;
      m_pre = (!en || m_tick) ? 0 : m_pre + 1;
      void'(sync_q.pop_front());
      sync_q.push_back({in_b, in_a});
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(cur_req, "cnt_o per-cycle", int'(cnt_o), m_cnt);
      chk(cur_req, "err_o per-cycle", int'(err_o), int'(m_err));
    end
  end

  task automatic drive(input logic a, input logic b, input int hold);
    @(negedge clk);
    in_a = a;
    in_b = b;
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic pulse_a(input logic b, input int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, b, 4);
      drive(1'b0, b, 4);
    end
  endtask

  task automatic phase_steps(input int n, input bit fwd, input int hold);
    logic [1:0] v;
    for (int i = 0; i < n; i++) begin
      ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
      v = gray(ph);
      drive(v[0], v[1], hold);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  int err_seen = 0;
  always @(negedge clk) if (cmp_on && err_o) err_seen++;

  initial begin
    rst_n = 1'b0; en = 1'b1; mode = 1'b0; pol = 1'b1; pre_code = 2'd0;
    in_a = 1'b0; in_b = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "cnt_o in reset", int'(cnt_o), 0);
    chk("R1", "err_o in reset", int'(err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cnt_o after reset", int'(cnt_o), 0);
    cmp_on = 1;

    cur_req = "R2";
    drive(1'b0, 1'b1, 4);
    pulse_a(1'b1, 4);
    settle();
    chk("R2", "rising edges, dir high", int'(cnt_o), 4);

    cur_req = "R4";
    drive(1'b0, 1'b0, 6);
    chk("R4", "direction change alone", int'(cnt_o), 4);
    pulse_a(1'b0, 3);
    settle();
    chk("R4", "pol1 dir low counts down", int'(cnt_o), 1);

    cur_req = "R3";
    pol = 1'b0;
    drive(1'b0, 1'b1, 6);
    pulse_a(1'b1, 2);
    settle();
    chk("R3", "falling edges pol0 dir high, wraps R10", int'(cnt_o), 16'hFFFF);

    cur_req = "R10";
    drive(1'b0, 1'b0, 6);
    pulse_a(1'b0, 1);
    settle();
    chk("R10", "0xFFFF plus one wraps", int'(cnt_o), 0);

    cur_req = "R5";
    mode = 1'b1; pol = 1'b1; ph = 0;
    settle();
    phase_steps(8, 1'b1, 3);
    settle();
    chk("R5", "A leads x4 up", int'(cnt_o), 8);
    phase_steps(4, 1'b0, 3);
    settle();
    chk("R5", "B leads down", int'(cnt_o), 4);

    cur_req = "R6";
    pol = 1'b0;
    settle();
    phase_steps(4, 1'b1, 3);
    settle();
    chk("R6", "A leads pol0 down", int'(cnt_o), 0);

    cur_req = "R7";
    err_seen = 0;
    drive(1'b1, 1'b1, 6);
    drive(1'b0, 1'b0, 6);
    settle();
    chk("R7", "count on double change", int'(cnt_o), 0);
    chk("R7", "error pulses seen", err_seen, 2);

    cur_req = "R8";
    pol = 1'b1; pre_code = 2'd3; ph = 0;
    settle();
    phase_steps(4, 1'b1, 6);
    settle();
    chk("R8", "divide by 4 count", int'(cnt_o), 4);
    pre_code = 2'd1;
    phase_steps(2, 1'b0, 6);
    settle();
    chk("R8", "divide by 2 count", int'(cnt_o), 2);
    pre_code = 2'd2;
    phase_steps(2, 1'b0, 6);
    settle();
    chk("R8", "divide by 3 count", int'(cnt_o), 0);
    pre_code = 2'd3;
    mode = 1'b0;
    drive(1'b0, 1'b1, 6);
    drive(1'b1, 1'b1, 1);
    drive(1'b0, 1'b1, 1);
    settle();
    mode = 1'b1;
    drive(1'b0, 1'b0, 8);
    pre_code = 2'd0;
    settle();
    m_cnt = m_cnt;

    cur_req = "R9";
    begin
      int base;
      base = int'(cnt_o);
      en = 1'b0;
      ph = 0;
      phase_steps(3, 1'b1, 3);
      settle();
      chk("R9", "hold while disabled", int'(cnt_o), base);
      en = 1'b1;
      settle();
      chk("R9", "no count after re-enable", int'(cnt_o), base);

      cur_req = "R11";
      @(negedge clk);
      in_a = 1'b0; in_b = 1'b0;
      @(negedge clk);
      chk("R11", "after edge k", int'(cnt_o), base);
      @(negedge clk);
      chk("R11", "after edge k+1", int'(cnt_o), base);
      @(negedge clk);
      chk("R11", "after edge k+2", int'(cnt_o), (base + 1) % 65536);
    end
    settle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule